// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block runs the digital side of a dual-slope integrating analog-to-digital converter. It drives three analog switches that feed the integrator: a discharge switch, the unknown signal, and a reference of opposite polarity. It also reads a comparator that reports when the integrator output has reached zero. A conversion first discharges the integrator. It then integrates the signal for a fixed number of clocks, called the run-up length. After that it integrates the reference and counts clocks until the comparator trips. The average input equals the reference times the de-integration count divided by the run-up length, so the count is the conversion result.

The run-up length is programmable. A run-up equal to one mains period removes line hum, because the hum averages to zero over that window. The length is captured when a conversion starts, so the setting may change at any time without disturbing a conversion already in progress. The de-integration is bounded. If the comparator has not tripped after twice the run-up length, the conversion ends with the result at that bound and an overrange flag set.

Top module: `dsadc_seq`

## Requirements
- R1: After reset the block is idle: all three switch outputs are low, and `busy`, `done`, `result` and `overrange` are all zero.
- R2: A `start` pulse sampled while idle begins a conversion and captures `t1_cfg` as the run-up length N, with a setting of 0 taken as N = 1. A `start` seen at any other time is ignored and neither restarts nor extends the conversion in progress.
- R3: A conversion closes `sw_rst` for exactly RST_CYC cycles, then `sw_sig` for exactly N cycles, then `sw_ref` until the conversion ends.
- R4: At most one of `sw_rst`, `sw_sig` and `sw_ref` is high in any cycle.
- R5: During the reference phase the cycle count starts at 0 and is sampled at each clock edge. In the first cycle in which `cmp_zero` (high = integrator at or below zero) is sampled high, `result` receives the number of reference cycles that came before it, and `overrange` is 0. If the comparator is already high in the first reference cycle, `result` is 0.
- R6: If the count reaches 2·N while `cmp_zero` is sampled low, the conversion ends with `result` = 2·N and `overrange` = 1.
- R7: Changes to `t1_cfg` after a conversion has started have no effect on its switch timing or on its result.
- R8: `busy` is high from the cycle after `start` is accepted until the conversion ends. `done` is then high for exactly one cycle, during which `busy` is low. `result` and `overrange` hold their values until the next conversion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a conversion (accepted when idle) |
| t1_cfg | input | CW | Run-up length in clocks (0 is taken as 1) |
| cmp_zero | input | 1 | Comparator output, high when the integrator is at or below zero |
| sw_sig | output | 1 | Connect the signal to the integrator |
| sw_ref | output | 1 | Connect the reference to the integrator |
| sw_rst | output | 1 | Discharge the integrator |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion pulse |
| result | output | CW+1 | De-integration count |
| overrange | output | 1 | Last conversion hit the 2·N bound |

## Verification
The bench attaches a behavioural integrator to the switch outputs. While the signal switch is closed, each clock adds the input value; while the reference switch is closed, each clock subtracts the reference value. The comparator is driven from the integrator's sign. Inputs at zero, in the middle of the range, at exactly 2·N worth of charge and above it separate a correct count from results that are off by one clock, an early or late stop, and a missing overrange flag. Random run-up lengths, including 0 and the largest setting, check that the switch phases follow the captured length. Runs that change `t1_cfg` or pulse `start` during a conversion show whether the captured length is really frozen and whether restarts are really blocked.

// File: rtl/dsadc_pkg.sv
// Shared types for the dual-slope sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dsadc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DISCH = 3'd1,
        ST_RUNUP = 3'd2,
        ST_RUNDN = 3'd3,
        ST_FIN   = 3'd4
    } dsadc_state_t;
endpackage

// File: rtl/dsadc_cnt.sv
// Phase counter: clears on request, otherwise counts up when enabled.
// Assumes: clr has priority over en; synchronous active-low reset.
module dsadc_cnt #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] q
);
    // Hold, clear or advance the cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (en)  q <= q + 1'b1;
    end
endmodule

// File: rtl/dsadc_fsm.sv
// Phase sequencer: discharge, signal run-up, reference run-down, finish.
// Assumes: n_len >= 1 and limit == 2*n_len, both stable while not idle;
// cnt is the phase counter that this module clears and enables.
module dsadc_fsm
    import dsadc_pkg::*;
#(
    parameter int CNW     = 13,
    parameter int RST_CYC = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           cmp_zero,
    input  logic [CNW-1:0] n_len,
    input  logic [CNW-1:0] limit,
    input  logic [CNW-1:0] cnt,
    output dsadc_state_t   state,
    output logic           cnt_clr,
    output logic           cnt_en,
    output logic           accept,
    output logic           fin,
    output logic           fin_ovr
);
    localparam logic [CNW-1:0] DISCH_LAST = CNW'(RST_CYC - 1);

    dsadc_state_t nxt;

    // Next state and counter control for each phase.
    always_comb begin
        nxt     = state;
        cnt_clr = 1'b0;
        cnt_en  = 1'b0;
        accept  = 1'b0;
        fin     = 1'b0;
        fin_ovr = 1'b0;
        unique case (state)
            ST_IDLE: if (start) begin
                nxt = ST_DISCH; cnt_clr = 1'b1; accept = 1'b1;
            end
            ST_DISCH: if (cnt == DISCH_LAST) begin
                nxt = ST_RUNUP; cnt_clr = 1'b1;
            end else cnt_en = 1'b1;
            ST_RUNUP: if (cnt == n_len - 1'b1) begin
                nxt = ST_RUNDN; cnt_clr = 1'b1;
            end else cnt_en = 1'b1;
            ST_RUNDN: if (cmp_zero) begin
                nxt = ST_FIN; fin = 1'b1;
            end else if (cnt == limit) begin
                nxt = ST_FIN; fin = 1'b1; fin_ovr = 1'b1;
            end else cnt_en = 1'b1;
            ST_FIN:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // R5: run-down continues while the comparator is low and the bound is not reached
    // R5
    rundown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUNDN && !cmp_zero && cnt < limit) |=> state == ST_RUNDN);

    // R6
    rundown_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUNDN) |-> cnt <= limit);

    // R3
    runup_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUNUP) |-> cnt < n_len);
endmodule

// File: rtl/dsadc_seq.sv
// Top of the dual-slope sequencer: captures the run-up length, drives the
// integrator switches and registers the de-integration count.
// Assumes: the comparator is already synchronised to clk; RST_CYC >= 1
// and RST_CYC < 2**(CW+1).
module dsadc_seq
    import dsadc_pkg::*;
#(
    parameter int CW      = 12,
    parameter int RST_CYC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [CW-1:0] t1_cfg,
    input  logic        cmp_zero,
    output logic        sw_sig,
    output logic        sw_ref,
    output logic        sw_rst,
    output logic        busy,
    output logic        done,
    output logic [CW:0] result,
    output logic        overrange
);
    localparam int CNW = CW + 1;

    dsadc_state_t   state;
    logic [CNW-1:0] cnt, n_len, limit;
    logic [CW-1:0]  t1_q;
    logic           cnt_clr, cnt_en, accept, fin, fin_ovr;

    assign n_len = (t1_q == '0) ? CNW'(1) : {1'b0, t1_q};
    assign limit = {n_len[CNW-2:0], 1'b0};

    // Freeze the run-up setting when a conversion is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      t1_q <= '0;
        else if (accept) t1_q <= t1_cfg;
    end

    dsadc_cnt #(.W(CNW)) i_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en), .q(cnt)
    );

    dsadc_fsm #(.CNW(CNW), .RST_CYC(RST_CYC)) i_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_zero(cmp_zero),
        .n_len(n_len), .limit(limit), .cnt(cnt), .state(state),
        .cnt_clr(cnt_clr), .cnt_en(cnt_en), .accept(accept),
        .fin(fin), .fin_ovr(fin_ovr)
    );

    // Register the count and the overrange flag at the end of run-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            overrange <= 1'b0;
        end else if (fin) begin
            result    <= fin_ovr ? limit : cnt;
            overrange <= fin_ovr;
        end
    end

    assign sw_rst = (state == ST_DISCH);
    assign sw_sig = (state == ST_RUNUP);
    assign sw_ref = (state == ST_RUNDN);
    assign busy   = sw_rst | sw_sig | sw_ref;
    assign done   = (state == ST_FIN);

    // R4
    sw_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_rst, sw_sig, sw_ref}));

    // R7
    t1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$rose(busy)) |-> $stable(t1_q));

    // R6
    ovr_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overrange) |-> result == limit);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(done) && !$rose(done)) |-> ($stable(result) || $past(!rst_n)));
endmodule

// File: tb/test_dsadc_seq.sv
// Bench for dsadc_seq: a behavioural integrator closes the loop, and each
// result is compared with a value computed from the input charge.
module test_dsadc_seq;
    localparam int CW = 12;
    localparam int RST_CYC = 4;
    localparam int VREF = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CW-1:0] t1_cfg = '0;
    logic cmp_zero;
    logic sw_sig, sw_ref, sw_rst, busy, done, overrange;
    logic [CW:0] result;

    int integ = 0;
    int vin = 0;
    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    dsadc_seq #(.CW(CW), .RST_CYC(RST_CYC)) i_dsadc_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .t1_cfg(t1_cfg),
        .cmp_zero(cmp_zero), .sw_sig(sw_sig), .sw_ref(sw_ref), .sw_rst(sw_rst),
        .busy(busy), .done(done), .result(result), .overrange(overrange)
    );

    // Integrator model: adds the input, subtracts the reference, or discharges.
    always @(posedge clk) begin
        if (sw_rst)      integ <= 0;
        else if (sw_sig) integ <= integ + vin;
        else if (sw_ref) integ <= integ - VREF;
    end
    assign cmp_zero = (integ <= 0);

    // Watchdog: counts an expiry as a failed check and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    function automatic int eff_len(int t1);
        return (t1 == 0) ? 1 : t1;
    endfunction

    // Expected count: ceil(vin*N/VREF), bounded at 2*N.
    function automatic int exp_count(int v, int n);
        int k;
        if (v <= 0) return 0;
        k = (v * n + VREF - 1) / VREF;
        return (k > 2 * n) ? 2 * n : k;
    endfunction

    function automatic bit exp_ovr(int v, int n);
        return (v > 0) && ((v * n + VREF - 1) / VREF > 2 * n);
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One conversion; optional mid-run t1 change and mid-run start pulse.
    task automatic convert(int v, int t1, bit chg_t1, bit re_start);
        int n_sig = 0, n_rst = 0, n_ref = 0, idle_bad = 0, multi = 0, it = 0;
        int n = eff_len(t1);
        vin = v;
        @(negedge clk);
        t1_cfg = CW'(t1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && it < 20000) begin
            if (sw_sig) n_sig++;
            if (sw_rst) n_rst++;
            if (sw_ref) n_ref++;
            if (!busy) idle_bad++;
            if ((32'(sw_sig) + 32'(sw_rst) + 32'(sw_ref)) > 1) multi++;
            if (chg_t1 && it == 1) t1_cfg = ~CW'(t1);
            if (re_start) start = (it == RST_CYC + 1);
            it++;
            @(negedge clk);
        end
        start = 1'b0;
        check("R3 discharge cycles", n_rst, RST_CYC);
        check("R3 run-up cycles (R7 frozen length)", n_sig, n);
        check("R5 result", int'(result), exp_count(v, n));
        check("R6 overrange", int'(overrange), int'(exp_ovr(v, n)));
        check("R4 switch overlap", multi, 0);
        check("R8 busy during conversion", idle_bad, 0);
        check("R8 busy low at done", int'(busy), 0);
        @(negedge clk);
        check("R8 done single cycle", int'(done), 0);
        check("R2 no restart after done", int'(busy), 0);
        check("R8 result held", int'(result), exp_count(v, n));
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 done after reset", int'(done), 0);
        check("R1 switches after reset", int'({sw_sig, sw_ref, sw_rst}), 0);
        check("R1 result after reset", int'(result), 0);
        check("R1 overrange after reset", int'(overrange), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 still idle", int'(busy), 0);

        convert(0, 10, 0, 0);              // R5 comparator high at once
        convert(500, 20, 0, 0);            // R5 mid-range
        convert(1000, 17, 0, 0);           // R5 exact full reference
        convert(2000, 13, 0, 0);           // R6 exactly at bound, no flag
        convert(2001, 13, 0, 0);           // R6 just over bound
        convert(3000, 9, 0, 0);            // R6 well over
        convert(700, 0, 0, 0);             // R2 zero length taken as one
        convert(999, 4095, 0, 0);          // largest length
        convert(640, 25, 1, 0);            // R7 length change mid-run
        convert(1234, 30, 0, 1);           // R2 start during conversion ignored
        for (int i = 0; i < 25; i++) begin
            int t1 = int'($urandom_range(1, 200));
            int v  = int'($urandom_range(0, 2300));
            convert(v, t1, ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule